// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two WIDTH-bit operands over several clock cycles and returns a 2*WIDTH-bit product. It retires one multiplier bit per cycle using a single WIDTH-bit adder.

The multiplier operand is not kept in a register of its own. It is loaded into the lower half of one 2*WIDTH-bit product register. Each step conditionally adds the multiplicand into the upper half, then shifts the whole register right by one. The adder's carry-out enters at the top.

A signed mode takes the magnitude of each operand before the loop. It negates the product in one final cycle when the operand signs disagree. A parameter can remove the signed path entirely.

The controller has four states:
- `ST_IDLE` waits for `start`. On a start it takes the **accept** transition to `ST_RUN` and loads the operands.
- `ST_RUN` performs one add-and-shift step per cycle. After the last of WIDTH steps it takes the **last-step** transition to `ST_FIX`.
- `ST_FIX` applies the conditional negation and takes the **finish** transition to `ST_DONE`.
- `ST_DONE` raises `done` for one cycle and takes the **release** transition back to `ST_IDLE`.

Top module: `seq_mul`

## Requirements
- R1: While `rst_n` is low and after its release, `hi`, `lo`, `busy` and `done` are all 0 until a start is accepted.
- R2: With `signed_mode` low, `{hi,lo}` at `done` equals the unsigned product of the operands captured at the accept edge. `hi` holds bits 2*WIDTH-1..WIDTH and `lo` holds bits WIDTH-1..0.
- R3: With `signed_mode` high, `{hi,lo}` at `done` is the 2*WIDTH-bit two's complement product of the two operands read as two's complement numbers.
- R4: A start is accepted only on a rising edge where `busy` is low. `busy` is high from the cycle after that edge until `done` falls.
- R5: `done` is high for exactly one cycle: the cycle following the (WIDTH+1)-th rising edge after the accepting edge.
- R6: `start` and operand changes while `busy` is high, including the cycle where `done` is high, are ignored. The running result and its timing are unaffected, and `busy` stays low after `done`.
- R7: `hi` and `lo` keep the last result unchanged while idle, until the next accepted start.
- R8: The carry out of the WIDTH-bit add is kept. The all-ones by all-ones unsigned case gives `hi` = all ones except bit 0, and `lo` = 1.
- R9: Signed edge cases are exact: the most negative value squared gives 2^(2*WIDTH-2), and a zero times a negative operand gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiply; sampled only when idle |
| signed_mode | input | 1 | 1: operands are two's complement; 0: unsigned |
| mcand | input | WIDTH | Multiplicand operand |
| mplier | input | WIDTH | Multiplier operand |
| hi | output | WIDTH | Upper half of the product register |
| lo | output | WIDTH | Lower half of the product register |
| busy | output | 1 | A multiply is in progress (`ST_RUN`, `ST_FIX`, `ST_DONE`) |
| done | output | 1 | One-cycle pulse: product is final |

## Verification
Two events can land in the same cycle: a new `start` request, and the completion pulse of the multiply already running. The bench raises `start`, with fresh operands, exactly in the cycle where `done` is observed high, and lowers it one edge later. The request is judged ignored if, after that edge, `busy` is low and `hi`/`lo` still show the first product unchanged. The same ignore rule is also exercised mid-run, where both the product and the WIDTH+1 edge latency must come out unchanged.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIX,
        ST_DONE
    } mul_state_e;
endpackage

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl
    import seq_mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic fix,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(WIDTH) + 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    mul_state_e state_q, state_d;
    logic [CNT_W-1:0] step_cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // step counter, cleared on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt_q <= '0;
        end else if (load) begin
            step_cnt_q <= '0;
        end else if (step) begin
            step_cnt_q <= step_cnt_q + 1'b1;
        end
    end

    // transitions: accept, last-step, finish, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (step_cnt_q == LAST_STEP) state_d = ST_FIX;
            ST_FIX:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        fix  = 1'b0;
        busy = 1'b1;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_RUN:  step = 1'b1;
            ST_FIX:  fix  = 1'b1;
            ST_DONE: done = 1'b1;
        endcase
    end
endmodule

// File: rtl/seq_mul_sign.sv
module seq_mul_sign #(
    parameter int WIDTH          = 32,
    parameter bit SIGNED_SUPPORT = 1'b1
) (
    input  logic             signed_mode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] mag_a,
    output logic [WIDTH-1:0] mag_b,
    output logic             negate
);
    generate
        if (SIGNED_SUPPORT) begin : g_signed
            logic a_neg, b_neg;
            assign a_neg  = signed_mode & op_a[WIDTH-1];
            assign b_neg  = signed_mode & op_b[WIDTH-1];
            // the most negative value maps to its own bit pattern, read as unsigned magnitude
            assign mag_a  = a_neg ? (~op_a + 1'b1) : op_a;
            assign mag_b  = b_neg ? (~op_b + 1'b1) : op_b;
            assign negate = a_neg ^ b_neg;
        end else begin : g_unsigned
            assign mag_a  = op_a;
            assign mag_b  = op_b;
            assign negate = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/seq_mul_datapath.sv
module seq_mul_datapath #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             fix,
    input  logic [WIDTH-1:0] mag_a,
    input  logic [WIDTH-1:0] mag_b,
    input  logic             negate,
    output logic [WIDTH-1:0] prod_hi,
    output logic [WIDTH-1:0] prod_lo
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0]    prod_q;
    logic [WIDTH-1:0] mcand_q;
    logic             neg_q;
    logic [WIDTH-1:0] addend;
    logic [WIDTH:0]   partial;

    // one WIDTH-bit adder; its carry is kept as bit WIDTH of partial
    assign addend  = prod_q[0] ? mcand_q : '0;
    assign partial = {1'b0, prod_q[PW-1:WIDTH]} + {1'b0, addend};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q  <= '0;
            mcand_q <= '0;
            neg_q   <= 1'b0;
        end else if (load) begin
            prod_q  <= {{WIDTH{1'b0}}, mag_b};
            mcand_q <= mag_a;
            neg_q   <= negate;
        end else if (step) begin
            prod_q  <= {partial, prod_q[WIDTH-1:1]};
        end else if (fix && neg_q) begin
            prod_q  <= ~prod_q + 1'b1;
        end
    end

    assign prod_hi = prod_q[PW-1:WIDTH];
    assign prod_lo = prod_q[WIDTH-1:0];
endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
    parameter int WIDTH          = 32,
    parameter bit SIGNED_SUPPORT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             signed_mode,
    input  logic [WIDTH-1:0] mcand,
    input  logic [WIDTH-1:0] mplier,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo,
    output logic             busy,
    output logic             done
);
    logic             load, step, fix, negate;
    logic [WIDTH-1:0] mag_a, mag_b;

    seq_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .fix   (fix),
        .busy  (busy),
        .done  (done)
    );

    seq_mul_sign #(.WIDTH(WIDTH), .SIGNED_SUPPORT(SIGNED_SUPPORT)) u_sign (
        .signed_mode (signed_mode),
        .op_a        (mcand),
        .op_b        (mplier),
        .mag_a       (mag_a),
        .mag_b       (mag_b),
        .negate      (negate)
    );

    seq_mul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .fix     (fix),
        .mag_a   (mag_a),
        .mag_b   (mag_b),
        .negate  (negate),
        .prod_hi (hi),
        .prod_lo (lo)
    );
endmodule

// File: rtl/seq_mul_chk.sv
module seq_mul_chk #(
    parameter int WIDTH          = 32,
    parameter bit SIGNED_SUPPORT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             signed_mode,
    input logic [WIDTH-1:0] mcand,
    input logic [WIDTH-1:0] mplier,
    input logic [WIDTH-1:0] hi,
    input logic [WIDTH-1:0] lo,
    input logic             busy,
    input logic             done
);
    localparam int LW = $clog2(WIDTH + 4) + 1;
    localparam logic [LW-1:0] LAT = LW'(WIDTH + 1);

    logic [WIDTH-1:0] a_q, b_q;
    logic             sgn_q;
    logic [LW-1:0]    lat_q;
    logic [2*WIDTH-1:0] exp_u, exp_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            sgn_q <= 1'b0;
            lat_q <= '0;
        end else if (start && !busy) begin
            a_q   <= mcand;
            b_q   <= mplier;
            sgn_q <= signed_mode && SIGNED_SUPPORT;
            lat_q <= '0;
        end else if (busy) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    assign exp_u = {{WIDTH{1'b0}}, a_q} * {{WIDTH{1'b0}}, b_q};
    assign exp_s = {{WIDTH{a_q[WIDTH-1]}}, a_q} * {{WIDTH{b_q[WIDTH-1]}}, b_q};

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> !done);

    p_unsigned_prod_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sgn_q) |-> ({hi, lo} == exp_u));

    p_signed_prod_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sgn_q) |-> ({hi, lo} == exp_s));

    p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == LAT));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({hi, lo}));
endmodule

bind seq_mul seq_mul_chk #(.WIDTH(WIDTH), .SIGNED_SUPPORT(SIGNED_SUPPORT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .mcand       (mcand),
    .mplier      (mplier),
    .hi          (hi),
    .lo          (lo),
    .busy        (busy),
    .done        (done)
);

// File: tb/seq_mul_bench.sv
module seq_mul_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         smode = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] hi, lo;
    logic         busy, done;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    seq_mul #(.WIDTH(W)) u_seq_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(smode),
        .mcand(op_a), .mplier(op_b), .hi(hi), .lo(lo), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b,
                                               input logic sgn);
        if (sgn) return {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
        return {{W{1'b0}}, a} * {{W{1'b0}}, b};
    endfunction

    task automatic wait_done(output int k);
        k = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            k++;
        end while (!done && k < W + 20);
    endtask

    task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b, input logic sgn);
        @(negedge clk);
        op_a = a; op_b = b; smode = sgn; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R4 busy after accept", busy, 1);
    endtask

    // plain multiply scenario
    task automatic t_mul(input logic [W-1:0] a, input logic [W-1:0] b, input logic sgn,
                         input string req);
        logic [2*W-1:0] expv;
        int k;
        expv = ref_prod(a, b, sgn);
        launch(a, b, sgn);
        wait_done(k);
        check(k == W + 1, "R5 done latency", k, W + 1);
        check({hi, lo} == expv, req, {hi, lo}, expv);
        @(negedge clk);
        check(!done && !busy, "R5 done single pulse", {done, busy}, 0);
    endtask

    // R6: start and new operands mid-run are ignored
    task automatic t_restart_ignored();
        logic [2*W-1:0] expv;
        int k;
        expv = ref_prod(32'h0001_2345, 32'h0000_0F0F, 1'b0);
        launch(32'h0001_2345, 32'h0000_0F0F, 1'b0);
        repeat (4) @(negedge clk);
        op_a = 32'hFFFF_FFFF; op_b = 32'h8000_0001; smode = 1'b1; start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        k = 7;
        do begin
            @(posedge clk);
            @(negedge clk);
            k++;
        end while (!done && k < W + 20);
        check(k == W + 1, "R6 latency unchanged by mid-run start", k, W + 1);
        check({hi, lo} == expv, "R6 product unchanged by mid-run start", {hi, lo}, expv);
    endtask

    // R6/R7: start raised in the done cycle is dropped, result holds
    task automatic t_start_on_done();
        logic [2*W-1:0] expv;
        int k;
        expv = ref_prod(32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
        launch(32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
        wait_done(k);
        op_a = 32'h0000_0003; op_b = 32'h0000_0005; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R6 start in done cycle ignored", busy, 0);
        check({hi, lo} == expv, "R6 result kept after done-cycle start", {hi, lo}, expv);
        repeat (6) @(negedge clk);
        check({hi, lo} == expv && !busy, "R7 idle hold", {hi, lo}, expv);
    endtask

    bit finished = 1'b0;

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({hi, lo} == '0 && !busy && !done, "R1 in reset", {hi, lo}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({hi, lo, busy, done} == '0, "R1 after release", {hi, lo}, 0);

        t_mul(32'd6, 32'd5, 1'b0, "R2 small unsigned");
        t_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R8 all-ones carry");
        t_mul(32'h8000_0000, 32'h8000_0000, 1'b0, "R2 top bits unsigned");
        t_mul(32'd0, 32'hFFFF_FFFF, 1'b0, "R2 zero operand");
        for (int i = 0; i < 6; i++) begin
            t_mul($urandom(), $urandom(), 1'b0, "R2 random unsigned");
        end
        t_mul(32'hFFFF_FFFD, 32'd7, 1'b1, "R3 neg times pos");
        t_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R3 neg times neg");
        t_mul(32'd9, 32'hFFFF_FFF0, 1'b1, "R3 pos times neg");
        t_mul(32'h8000_0000, 32'h8000_0000, 1'b1, "R9 min squared");
        t_mul(32'h8000_0000, 32'd1, 1'b1, "R9 min times one");
        t_mul(32'd0, 32'hFFFF_FF00, 1'b1, "R9 zero times negative");
        for (int i = 0; i < 6; i++) begin
            t_mul($urandom(), $urandom(), 1'b1, "R3 random signed");
        end
        t_restart_ignored();
        t_start_on_done();

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule